// File: doc/BRIEF.md
# DS3 Maintenance Signal Pattern Detector

This block watches a DS3 receive bit stream after an upstream framer has found alignment. Once per M-frame it decides whether the frame carried the alarm indication signal (AIS), the idle signal, or a far-end yellow alarm. The framer supplies the following with each bit:

- a valid qualifier and an overhead/payload marker
- strobes that tag C-bits and X-bits
- the index of the subframe being received
- framing-valid and parity-valid levels
- a one-cycle pulse at each M-frame boundary

Between boundaries the detector builds up evidence about the frame. It tracks whether every C-bit, and every C-bit of subframe 3, was zero. It tracks whether the two X-bits agreed and whether both were low. It also tracks whether each payload bit matched the AIS or idle pattern. A payload phase counter restarts at every overhead bit. At the boundary the evidence becomes three registered flags, and the evidence is then cleared.

A mode input selects E3 behaviour. In E3 mode the X-bit strobe instead tags the received A-bit, yellow follows that bit, and AIS and idle stay low. A loss of framing clears every flag and sends the block back to a hunt state. In the hunt state the next boundary only re-arms the block, because the frame that ends there was seen only in part.

Top module: `ds3_maint_detect`

## Requirements
- R1: In DS3 mode, at a boundary while tracking, aisDet is set when all of these hold: parityValid is high, exactly 21 C-bits were strobed and all were 0, exactly 2 X-bits were strobed and they were equal, and at least one payload bit was seen. In addition, every payload bit must match the alternating pattern whose bit at phase p is 1 for even p.
- R2: In DS3 mode, at a boundary while tracking, idleDet is set when all of these hold: parityValid is high, exactly 3 C-bits were strobed with subframeIdx equal to 3 and all were 0, and the 2 X-bits were equal. In addition, every payload bit must match the pattern whose bit at phase p is 1 for p mod 4 equal to 0 or 1. C-bits of other subframes do not matter.
- R3: The payload phase is 0 on the first payload bit after any overhead bit and advances by one per payload bit. A single mismatching payload bit anywhere in the M-frame clears the AIS or idle result for that frame.
- R4: In DS3 mode, yellowDet is set at a tracked boundary when both X-bits of the ending frame were 0. It is re-evaluated at the next boundary, so it lasts one M-frame interval.
- R5: In E3 mode, aisDet and idleDet are low from the cycle after e3Mode is high. At a tracked boundary, yellowDet takes the value of the last bit strobed by xStrobe (the A-bit) in that frame.
- R6: Reset, or frameValid low, clears all three flags in the next cycle and enters hunt. The first boundary seen with frameValid high while hunting leaves all flags low and starts tracking.
- R7: Flags change only in the cycle after a boundary pulse, a reset, a frameValid drop or (for AIS/idle) E3 mode. Otherwise they hold.
- R8: A boundary with parityValid low yields aisDet and idleDet low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| e3Mode | input | 1 | 1 selects E3 behaviour, 0 selects DS3 |
| frameValid | input | 1 | Framer reports alignment |
| parityValid | input | 1 | Frame parity good, sampled at the boundary |
| mfBoundary | input | 1 | One-cycle M-frame end pulse; bit inputs are ignored in that cycle |
| bitValid | input | 1 | A received bit is present this cycle |
| rxBit | input | 1 | Received bit value |
| isOverhead | input | 1 | 1 marks an overhead bit, 0 a payload bit |
| cStrobe | input | 1 | Overhead bit is a C-bit |
| xStrobe | input | 1 | Overhead bit is an X-bit (the A-bit in E3 mode) |
| subframeIdx | input | 3 | Subframe number 1..7 of the current bit |
| aisDet | output | 1 | AIS found in the previous M-frame |
| idleDet | output | 1 | Idle signal found in the previous M-frame |
| yellowDet | output | 1 | Far-end yellow alarm |

## Verification
Payload blocks have random lengths, so the phase rarely lands on a multiple of four at an overhead bit. A detector that failed to restart the phase would then miss valid AIS and idle frames. Single flipped payload bits, one stray C-bit, unequal X-bits and bad parity each probe one qualifier, and a detector ignoring that qualifier would raise a false alarm. The bench checks that idle tolerates ones in C-bits outside subframe 3, that yellow drops one frame after the X-bits return high, and that a framing loss leaves the next boundary silent. It also checks that a switch to E3 silences AIS and idle at once. A design lacking the hunt state would report on a partial frame, and one still decoding idle in E3 would leave the flag high.

// File: rtl/maint_det_pkg.sv
package maint_det_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic clrAcc;     // drop per-frame evidence
    logic clrFlags;   // force every flag low
    logic ohBit;      // valid overhead bit
    logic payBit;     // valid payload bit
    logic cBit;       // overhead bit tagged as C-bit
    logic cSf3;       // C-bit that belongs to subframe 3
    logic xBit;       // X-bit (A-bit in E3)
    logic evalFrame;  // boundary while tracking
    logic huntBnd;    // boundary while hunting
    logic parityOk;   // parity qualifier at the boundary
    logic e3;         // E3 behaviour selected
  } ctrlStrobes_t;

endpackage

// File: rtl/maint_det_ctrl.sv
module maint_det_ctrl
  import maint_det_pkg::*;
#(
  parameter int SF_W    = 3,
  parameter int SF3_IDX = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            e3Mode,
  input  logic            frameValid,
  input  logic            parityValid,
  input  logic            mfBoundary,
  input  logic            bitValid,
  input  logic            isOverhead,
  input  logic            cStrobe,
  input  logic            xStrobe,
  input  logic [SF_W-1:0] subframeIdx,
  output ctrlStrobes_t    strb
);

  typedef enum logic {ST_HUNT, ST_TRACK} trackState_t;
  trackState_t state;
  logic lossNow;
  logic bitGo;

  assign lossNow = rst | ~frameValid;
  assign bitGo   = bitValid & ~mfBoundary & ~lossNow;

  always_ff @(posedge clk) begin
    if (lossNow)         state <= ST_HUNT;
    else if (mfBoundary) state <= ST_TRACK;
  end

  always_comb begin
    strb           = '0;
    strb.clrFlags  = lossNow;
    strb.clrAcc    = lossNow | mfBoundary;
    strb.ohBit     = bitGo & isOverhead;
    strb.payBit    = bitGo & ~isOverhead;
    strb.cBit      = bitGo & isOverhead & cStrobe;
    strb.cSf3      = bitGo & isOverhead & cStrobe &
                     (subframeIdx == SF_W'(SF3_IDX));
    strb.xBit      = bitGo & isOverhead & xStrobe;
    strb.evalFrame = mfBoundary & ~lossNow & (state == ST_TRACK);
    strb.huntBnd   = mfBoundary & ~lossNow & (state == ST_HUNT);
    strb.parityOk  = parityValid;
    strb.e3        = e3Mode;
  end

  AST_HUNT_AFTER_LOSS: assert property (@(posedge clk) disable iff (rst)
    !frameValid |=> state == ST_HUNT);  // R6

  AST_TRACK_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (frameValid && mfBoundary) |=> state == ST_TRACK);  // R6

endmodule

// File: rtl/maint_det_dp.sv
module maint_det_dp
  import maint_det_pkg::*;
#(
  parameter int C_PER_MF = 21,
  parameter int SF3_C    = 3,
  parameter int X_PER_MF = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rxBit,
  input  ctrlStrobes_t strb,
  output logic         aisDet,
  output logic         idleDet,
  output logic         yellowDet
);

  localparam int C_W     = $clog2(C_PER_MF + 2);
  localparam int S_W     = $clog2(SF3_C + 2);
  localparam int X_W     = $clog2(X_PER_MF + 2);
  localparam int PHASE_W = 2;

  logic [PHASE_W-1:0] phase;
  logic [C_W-1:0]     cCount;
  logic [S_W-1:0]     sf3Count;
  logic [X_W-1:0]     xCount;
  logic aisOk, idleOk, paySeen;
  logic cZero, sf3Zero;
  logic xFirst, xEqual, xAllLow;
  logic aSeen, aVal;

  logic aisWant, idleWant;
  logic xGood, ds3Ais, ds3Idle, ds3Yel;

  // pattern bit expected at the current payload phase
  assign aisWant  = ~phase[0];
  assign idleWant = ~phase[1];

  // evidence gathered across one M-frame
  always_ff @(posedge clk) begin
    if (strb.clrAcc) begin
      phase    <= '0;
      aisOk    <= 1'b1;
      idleOk   <= 1'b1;
      paySeen  <= 1'b0;
      cZero    <= 1'b1;
      sf3Zero  <= 1'b1;
      cCount   <= '0;
      sf3Count <= '0;
      xCount   <= '0;
      xFirst   <= 1'b0;
      xEqual   <= 1'b1;
      xAllLow  <= 1'b1;
      aSeen    <= 1'b0;
      aVal     <= 1'b0;
    end else begin
      if (strb.ohBit) phase <= '0;
      if (strb.payBit) begin
        phase   <= phase + 1'b1;
        paySeen <= 1'b1;
        if (rxBit != aisWant)  aisOk  <= 1'b0;
        if (rxBit != idleWant) idleOk <= 1'b0;
      end
      if (strb.cBit) begin
        if (cCount != C_W'(C_PER_MF + 1)) cCount <= cCount + 1'b1;
        if (rxBit) cZero <= 1'b0;
      end
      if (strb.cSf3) begin
        if (sf3Count != S_W'(SF3_C + 1)) sf3Count <= sf3Count + 1'b1;
        if (rxBit) sf3Zero <= 1'b0;
      end
      if (strb.xBit) begin
        if (xCount == '0)       xFirst <= rxBit;
        else if (rxBit != xFirst) xEqual <= 1'b0;
        if (xCount != X_W'(X_PER_MF + 1)) xCount <= xCount + 1'b1;
        if (rxBit) xAllLow <= 1'b0;
        aSeen <= 1'b1;
        aVal  <= rxBit;
      end
    end
  end

  assign xGood   = (xCount == X_W'(X_PER_MF)) & xEqual;
  assign ds3Ais  = strb.parityOk & cZero & (cCount == C_W'(C_PER_MF)) &
                   xGood & paySeen & aisOk;
  assign ds3Idle = strb.parityOk & sf3Zero & (sf3Count == S_W'(SF3_C)) &
                   xGood & paySeen & idleOk;
  assign ds3Yel  = (xCount == X_W'(X_PER_MF)) & xAllLow;

  // per-frame verdict registers
  always_ff @(posedge clk) begin
    if (strb.clrFlags) begin
      aisDet    <= 1'b0;
      idleDet   <= 1'b0;
      yellowDet <= 1'b0;
    end else begin
      if (strb.evalFrame) begin
        aisDet    <= ds3Ais;
        idleDet   <= ds3Idle;
        yellowDet <= strb.e3 ? (aSeen & aVal) : ds3Yel;
      end else if (strb.huntBnd) begin
        aisDet    <= 1'b0;
        idleDet   <= 1'b0;
        yellowDet <= 1'b0;
      end
      if (strb.e3) begin
        aisDet  <= 1'b0;
        idleDet <= 1'b0;
      end
    end
  end

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (rst)
    (strb.ohBit && !strb.clrAcc) |=> phase == '0);  // R3

  AST_E3_QUIET: assert property (@(posedge clk) disable iff (rst)
    strb.e3 |=> (!aisDet && !idleDet));  // R5

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    (!strb.evalFrame && !strb.huntBnd && !strb.clrFlags && !strb.e3)
      |=> ($stable(aisDet) && $stable(idleDet) && $stable(yellowDet)));  // R7

  AST_MISMATCH_KILLS: assert property (@(posedge clk) disable iff (rst)
    (strb.payBit && !strb.clrAcc && rxBit != aisWant) |=> !aisOk);  // R3

endmodule

// File: rtl/ds3_maint_detect.sv
module ds3_maint_detect
  import maint_det_pkg::*;
#(
  parameter int C_PER_MF = 21,
  parameter int SF3_C    = 3,
  parameter int X_PER_MF = 2,
  parameter int SF_W     = 3,
  parameter int SF3_IDX  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            e3Mode,
  input  logic            frameValid,
  input  logic            parityValid,
  input  logic            mfBoundary,
  input  logic            bitValid,
  input  logic            rxBit,
  input  logic            isOverhead,
  input  logic            cStrobe,
  input  logic            xStrobe,
  input  logic [SF_W-1:0] subframeIdx,
  output logic            aisDet,
  output logic            idleDet,
  output logic            yellowDet
);

  ctrlStrobes_t strb;

  maint_det_ctrl #(
    .SF_W    (SF_W),
    .SF3_IDX (SF3_IDX)
  ) uCtrl (
    .clk         (clk),
    .rst         (rst),
    .e3Mode      (e3Mode),
    .frameValid  (frameValid),
    .parityValid (parityValid),
    .mfBoundary  (mfBoundary),
    .bitValid    (bitValid),
    .isOverhead  (isOverhead),
    .cStrobe     (cStrobe),
    .xStrobe     (xStrobe),
    .subframeIdx (subframeIdx),
    .strb        (strb)
  );

  maint_det_dp #(
    .C_PER_MF (C_PER_MF),
    .SF3_C    (SF3_C),
    .X_PER_MF (X_PER_MF)
  ) uDp (
    .clk       (clk),
    .rst       (rst),
    .rxBit     (rxBit),
    .strb      (strb),
    .aisDet    (aisDet),
    .idleDet   (idleDet),
    .yellowDet (yellowDet)
  );

  AST_NOFRAME_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !frameValid |=> (!aisDet && !idleDet && !yellowDet));  // R6

  AST_PARITY_GATE: assert property (@(posedge clk) disable iff (rst)
    (mfBoundary && !parityValid) |=> (!aisDet && !idleDet));  // R8

endmodule

// File: tb/tb_ds3_maint_detect.sv
module tb_ds3_maint_detect;

  localparam int CLK_PERIOD = 10;
  localparam int KIND_AIS   = 0;
  localparam int KIND_IDLE  = 1;
  localparam int KIND_RAND  = 2;

  logic clk = 1'b0;
  logic rst, e3Mode, frameValid, parityValid, mfBoundary;
  logic bitValid, rxBit, isOverhead, cStrobe, xStrobe;
  logic [2:0] subframeIdx;
  logic aisDet, idleDet, yellowDet;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  // bench model of the current frame
  bit mAisOk, mIdleOk, mCz, mSf3z, mXa, mXb, mLastA, armed;
  int mPhase, mPayIdx;
  bit pAis, pIdle, pYel;

  always #(CLK_PERIOD/2) clk = ~clk;

  ds3_maint_detect dut (
    .clk(clk), .rst(rst), .e3Mode(e3Mode), .frameValid(frameValid),
    .parityValid(parityValid), .mfBoundary(mfBoundary), .bitValid(bitValid),
    .rxBit(rxBit), .isOverhead(isOverhead), .cStrobe(cStrobe),
    .xStrobe(xStrobe), .subframeIdx(subframeIdx), .aisDet(aisDet),
    .idleDet(idleDet), .yellowDet(yellowDet)
  );

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string req, input bit eA, input bit eI, input bit eY);
    check(req, "aisDet", aisDet, eA);
    check(req, "idleDet", idleDet, eI);
    check(req, "yellowDet", yellowDet, eY);
  endtask

  function automatic bit aisBitAt(input int ph);
    return (ph % 2) == 0;
  endfunction

  function automatic bit idleBitAt(input int ph);
    return (ph % 4) < 2;
  endfunction

  task automatic sendBit(input bit ovh, input bit c, input bit x,
                         input int sf, input bit val);
    if ($urandom_range(0, 7) == 0) begin
      @(negedge clk);
      bitValid = 1'b0;
      rxBit    = $urandom_range(0, 1);
    end
    @(negedge clk);
    bitValid    = 1'b1;
    isOverhead  = ovh;
    cStrobe     = c;
    xStrobe     = x;
    subframeIdx = 3'(sf);
    rxBit       = val;
  endtask

  task automatic boundary(input bit fv, input bit pv, input bit e3);
    bit eA, eI, eY;
    @(negedge clk);
    bitValid    = 1'b0;
    mfBoundary  = 1'b1;
    frameValid  = fv;
    parityValid = pv;
    e3Mode      = e3;
    if (!fv) begin
      eA = 0; eI = 0; eY = 0; armed = 0;
    end else if (!armed) begin
      eA = 0; eI = 0; eY = 0; armed = 1;
    end else begin
      eA = !e3 && pv && mCz && (mXa == mXb) && mAisOk;
      eI = !e3 && pv && mSf3z && (mXa == mXb) && mIdleOk;
      eY = e3 ? mLastA : (!mXa && !mXb);
    end
    @(negedge clk);
    mfBoundary  = 1'b0;
    parityValid = 1'b1;
    if (!pv && fv && armed) checkAll("R8", eA, eI, eY);
    else if (e3 && fv)      checkAll("R5", eA, eI, eY);
    else                    checkAll("R1 R2 R4 R6", eA, eI, eY);
    pAis = eA; pIdle = eI; pYel = eY;
  endtask

  // one M-frame: 7 subframes of 8 overhead bits with payload blocks between
  task automatic sendFrame(input int kind, input bit e3, input bit fv, input bit pv,
                           input bit xa, input bit xb, input logic [20:0] cOnes,
                           input int errIdx);
    int cIdx = 0;
    mAisOk = 1; mIdleOk = 1; mCz = 1; mSf3z = 1;
    mXa = xa; mXb = xb; mLastA = xb; mPhase = 0; mPayIdx = 0;
    e3Mode = e3;
    frameValid = fv;
    if (!fv) begin
      armed = 0;
    end
    if (e3) begin
      pAis = 0; pIdle = 0;
    end
    for (int sf = 1; sf <= 7; sf++) begin
      for (int blk = 0; blk < 8; blk++) begin
        bit isC, isX, v;
        isX = (blk == 0) && (sf <= 2);
        isC = (blk == 2) || (blk == 4) || (blk == 6);
        if (isX)      v = (sf == 1) ? xa : xb;
        else if (isC) v = cOnes[cIdx];
        else          v = $urandom_range(0, 1);
        if (isC) begin
          if (v) mCz = 0;
          if (v && sf == 3) mSf3z = 0;
          cIdx++;
        end
        sendBit(1'b1, isC, isX, sf, v);
        mPhase = 0;
        if (!fv && sf == 1 && blk == 0) begin
          @(negedge clk);
          bitValid = 1'b0;
          pAis = 0; pIdle = 0; pYel = 0;
          checkAll("R6", 1'b0, 1'b0, 1'b0);
        end
        for (int k = 0; k < int'($urandom_range(3, 9)); k++) begin
          bit pb;
          if (kind == KIND_AIS)       pb = aisBitAt(mPhase);
          else if (kind == KIND_IDLE) pb = idleBitAt(mPhase);
          else                        pb = $urandom_range(0, 1);
          if (mPayIdx == errIdx) pb = ~pb;
          if (pb != aisBitAt(mPhase))  mAisOk = 0;
          if (pb != idleBitAt(mPhase)) mIdleOk = 0;
          sendBit(1'b0, 1'b0, 1'b0, sf, pb);
          mPhase = (mPhase + 1) % 4;
          mPayIdx++;
        end
      end
      if (sf == 4) checkAll("R7", pAis, pIdle, pYel);
    end
    boundary(fv, pv, e3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      misses++;
      vectors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst = 1; e3Mode = 0; frameValid = 1; parityValid = 1; mfBoundary = 0;
    bitValid = 0; rxBit = 0; isOverhead = 0; cStrobe = 0; xStrobe = 0;
    subframeIdx = 3'd1; armed = 0; pAis = 0; pIdle = 0; pYel = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checkAll("R6 reset", 1'b0, 1'b0, 1'b0);

    // lead-in: hunt boundary re-arms only (R6)
    boundary(1, 1, 0);

    // R1 clean AIS with random block lengths (R3 phase restart)
    sendFrame(KIND_AIS, 0, 1, 1, 1, 1, 21'h0, -1);
    // R2 idle tolerates ones in C-bits outside subframe 3
    sendFrame(KIND_IDLE, 0, 1, 1, 1, 1, 21'h1FFE3F, -1);
    // R3 one flipped payload bit
    sendFrame(KIND_AIS, 0, 1, 1, 1, 1, 21'h0, 37);
    sendFrame(KIND_IDLE, 0, 1, 1, 0, 0, 21'h0, 100);
    // R2 unequal X-bits
    sendFrame(KIND_IDLE, 0, 1, 1, 1, 0, 21'h0, -1);
    // R8 bad parity
    sendFrame(KIND_AIS, 0, 1, 0, 1, 1, 21'h0, -1);
    // R4 yellow for one interval
    sendFrame(KIND_AIS, 0, 1, 1, 0, 0, 21'h0, -1);
    sendFrame(KIND_AIS, 0, 1, 1, 1, 1, 21'h0, -1);
    // R1 a single stray C-bit
    sendFrame(KIND_AIS, 0, 1, 1, 1, 1, 21'h010000, -1);
    // R6 framing loss, then hunt, then tracking
    sendFrame(KIND_AIS, 0, 0, 1, 1, 1, 21'h0, -1);
    sendFrame(KIND_AIS, 0, 1, 1, 1, 1, 21'h0, -1);
    sendFrame(KIND_AIS, 0, 1, 1, 1, 1, 21'h0, -1);
    // R5 switch to E3 silences idle at once
    sendFrame(KIND_IDLE, 0, 1, 1, 1, 1, 21'h0, -1);
    @(negedge clk);
    e3Mode = 1;
    @(negedge clk);
    check("R5", "idleDet after E3 switch", idleDet, 1'b0);
    check("R5", "aisDet after E3 switch", aisDet, 1'b0);
    sendFrame(KIND_IDLE, 1, 1, 1, 0, 1, 21'h0, -1);
    sendFrame(KIND_AIS, 1, 1, 1, 1, 0, 21'h0, -1);

    // constrained random frames
    for (int n = 0; n < 30; n++) begin
      int kind, cm, err;
      logic [20:0] ones;
      kind = $urandom_range(0, 2);
      cm   = $urandom_range(0, 3);
      ones = 21'($urandom());
      if (cm < 2)       ones = 21'h0;
      else if (cm == 2) ones[8:6] = 3'b000;
      err = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 150)) : -1;
      sendFrame(kind, $urandom_range(0, 6) == 0, $urandom_range(0, 19) != 0,
                $urandom_range(0, 9) != 0, $urandom_range(0, 1),
                $urandom_range(0, 1), ones, err);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule